// File: doc/BRIEF.md
# Cycle-Timed Register Write Scheduler

This block sits in front of a sound generator's byte-wide register bus. It lets the writes land on the exact chip clock cycles they were meant for, even though the commands reach it at an uneven rate. Each command carries three fields: an absolute chip-cycle timestamp, a register number and a data byte. Commands enter through a valid/ready handshake and wait in a first-in first-out queue.

A chip-cycle counter advances once for every pulse of `tick_en`. The block drives one `tick_en` pulse per period of the sound chip's clock, which is near 1 MHz. The head of the queue is checked against this counter on each tick. When it is due, the block drives one bus write: chip select and write strobe go low, and the register number and byte are presented. This write lasts for one tick period.

The due test takes the difference of counter and timestamp as a signed number. A timestamp stays valid across counter wraparound as long as it lies within half the counter range of the current cycle. Two conditions set flags that stay set until reset: a command that was already overdue when it was released, and a command aimed at a register that does not exist.

Top module: `cyc_write_sched`

## Requirements
- R1: After reset the queue is empty and the cycle counter is zero. `bus_cs_n` and `bus_we_n` are high, `cmd_ready` is high, and both `late_flag` and `addr_err_flag` are low.
- R2: The cycle counter advances by one on every clock edge where `tick_en` is high, holds otherwise, and wraps modulo 2^TS_W. The tick edge that sees counter value N is the (N+1)-th tick since reset.
- R3: A queued command whose timestamp equals the counter at a tick edge is written at that edge. From then until the next tick edge, `bus_cs_n` and `bus_we_n` are both 0 (active low), `bus_addr` holds the register number and `bus_data` holds the byte.
- R4: At most one write is issued per tick. Several commands that are due together drain on consecutive ticks.
- R5: A command is due when (counter − timestamp), taken as a TS_W-bit two's-complement value, is zero or positive. Timestamps that lie beyond a counter wrap are therefore released at the correct tick.
- R6: A command that is already past due when it reaches the head of the queue is written at the next tick. Releasing it sets `late_flag`, which stays high until reset. A release that is exactly on time leaves the flag unchanged.
- R7: The queue holds DEPTH (default 16) commands. `cmd_ready` is low exactly while the queue is full, and `cmd_valid` has no effect while `cmd_ready` is low.
- R8: A command accepted with a register number of REG_COUNT (default 25, so 0x19) or above is discarded and never written. Accepting it sets `addr_err_flag`, which stays high until reset. Register numbers 0x00 to 0x18 are queued.
- R9: At a tick where the queue is empty or the head command is not yet due, no write is issued, and `bus_cs_n` and `bus_we_n` are high for the following tick period.
- R10: Commands are written in the order they were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-cycle pulse per sound-chip clock period |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Queue can take a command |
| cmd_time | input | TS_W | Absolute chip cycle at which to write |
| cmd_addr | input | ADDR_W | Target register number |
| cmd_data | input | DATA_W | Byte to write |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_we_n | output | 1 | Write strobe, active low |
| bus_addr | output | ADDR_W | Register number on the bus |
| bus_data | output | DATA_W | Data byte on the bus |
| late_flag | output | 1 | Sticky: an overdue command was released |
| addr_err_flag | output | 1 | Sticky: a command with an illegal register number was discarded |

## Verification
The bench builds the block with an 8-bit timestamp so that the counter wraps within a few hundred ticks. It then tries the following patterns:
- A sweep of all 32 register numbers with timestamps one tick apart. This exercises back-to-back writes, order and the legal/illegal address boundary at 0x18/0x19.
- Commands that share a timestamp, which separates "one write per tick" from issuing several at once.
- An overdue timestamp, which separates an on-time release from a late one.
- Timestamps placed across the counter wrap, which expose an unsigned compare.
- A full queue followed by an extra offer, plus a reset in the middle of a run. These check back-pressure and that the counter restarts from zero.

// File: rtl/sched_pkg.sv
package sched_pkg;
   localparam int unsigned REG_COUNT_DEF = 25;
   localparam int unsigned DEPTH_DEF     = 16;

   typedef enum logic {
      BUS_IDLE  = 1'b0,
      BUS_WRITE = 1'b1
   } bus_state_e;
endpackage

// File: rtl/sched_timebase.sv
module sched_timebase #(
   parameter int unsigned TS_W = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tick_en,
   output logic [TS_W-1:0] cycle_q
);
   generate
      if (TS_W < 2) begin : g_bad_width
         $fatal(1, "sched_timebase: TS_W must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cycle_q <= '0;
      else if (tick_en) cycle_q <= cycle_q + 1'b1;
   end
endmodule

// File: rtl/sched_fifo.sv
module sched_fifo #(
   parameter int unsigned W     = 45,
   parameter int unsigned DEPTH = 16,
   localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [W-1:0]     push_data,
   input  logic             pop,
   output logic [W-1:0]     head,
   output logic             full,
   output logic             empty,
   output logic [LVL_W-1:0] level
);
   localparam bit POW2 = ((DEPTH & (DEPTH - 1)) == 0);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $fatal(1, "sched_fifo: DEPTH must be at least 2");
      end
   endgenerate

   logic [W-1:0]     mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic             do_push, do_pop;

   assign do_push = push && !full;
   assign do_pop  = pop && !empty;

   generate
      if (POW2) begin : g_wrap_free
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_wrap_cmp
         assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= push_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_nxt;
         if (do_pop)  rd_ptr <= rd_nxt;
         case ({do_push, do_pop})
            2'b10:   level <= level + 1'b1;
            2'b01:   level <= level - 1'b1;
            default: level <= level;
         endcase
      end
   end

   assign head  = mem[rd_ptr];
   assign full  = (level == LVL_W'(DEPTH));
   assign empty = (level == '0);
endmodule

// File: rtl/sched_issue.sv
module sched_issue
   import sched_pkg::*;
#(
   parameter int unsigned TS_W   = 32,
   parameter int unsigned ADDR_W = 5,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic [TS_W-1:0]   cycle_now,
   input  logic              head_valid,
   input  logic [TS_W-1:0]   head_ts,
   input  logic [ADDR_W-1:0] head_addr,
   input  logic [DATA_W-1:0] head_data,
   output logic              pop,
   output logic              bus_cs_n,
   output logic              bus_we_n,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_data,
   output logic              late_flag
);
   logic [TS_W-1:0] age;
   logic            due, overdue, fire;
   bus_state_e      state_q;

   // age is counter minus stamp; its sign bit marks "still in the future"
   assign age     = cycle_now - head_ts;
   assign due     = head_valid && !age[TS_W-1];
   assign overdue = (age != '0);
   assign fire    = tick_en && due;
   assign pop     = fire;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= BUS_IDLE;
         bus_addr  <= '0;
         bus_data  <= '0;
         late_flag <= 1'b0;
      end else if (tick_en) begin
         state_q <= fire ? BUS_WRITE : BUS_IDLE;
         if (fire) begin
            bus_addr <= head_addr;
            bus_data <= head_data;
            if (overdue) late_flag <= 1'b1;
         end
      end
   end

   assign bus_cs_n = (state_q != BUS_WRITE);
   assign bus_we_n = (state_q != BUS_WRITE);
endmodule

// File: rtl/cyc_write_sched.sv
module cyc_write_sched
   import sched_pkg::*;
#(
   parameter int unsigned TS_W      = 32,
   parameter int unsigned ADDR_W    = 5,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned DEPTH     = DEPTH_DEF,
   parameter int unsigned REG_COUNT = REG_COUNT_DEF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              cmd_valid,
   output logic              cmd_ready,
   input  logic [TS_W-1:0]   cmd_time,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [DATA_W-1:0] cmd_data,
   output logic              bus_cs_n,
   output logic              bus_we_n,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_data,
   output logic              late_flag,
   output logic              addr_err_flag
);
   localparam int unsigned ENT_W = TS_W + ADDR_W + DATA_W;
   localparam int unsigned LVL_W = $clog2(DEPTH + 1);

   generate
      if (REG_COUNT < 1 || REG_COUNT > (1 << ADDR_W)) begin : g_bad_regs
         $fatal(1, "cyc_write_sched: REG_COUNT must fit in ADDR_W bits");
      end
   endgenerate

   logic              addr_ok, accept, do_push, fifo_full, fifo_empty, do_pop;
   logic [ENT_W-1:0]  head_ent;
   logic [LVL_W-1:0]  fifo_level;
   logic [TS_W-1:0]   cycle_q;

   generate
      if (REG_COUNT == (1 << ADDR_W)) begin : g_addr_all
         assign addr_ok = 1'b1;
      end else begin : g_addr_cmp
         assign addr_ok = ({1'b0, cmd_addr} < (ADDR_W + 1)'(REG_COUNT));
      end
   endgenerate

   assign cmd_ready = !fifo_full;
   assign accept    = cmd_valid && cmd_ready;
   assign do_push   = accept && addr_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  addr_err_flag <= 1'b0;
      else if (accept && !addr_ok) addr_err_flag <= 1'b1;
   end

   sched_timebase #(.TS_W(TS_W)) u_time (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_en (tick_en),
      .cycle_q (cycle_q)
   );

   sched_fifo #(.W(ENT_W), .DEPTH(DEPTH)) u_queue (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (do_push),
      .push_data ({cmd_time, cmd_addr, cmd_data}),
      .pop       (do_pop),
      .head      (head_ent),
      .full      (fifo_full),
      .empty     (fifo_empty),
      .level     (fifo_level)
   );

   sched_issue #(.TS_W(TS_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_issue (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_en    (tick_en),
      .cycle_now  (cycle_q),
      .head_valid (!fifo_empty),
      .head_ts    (head_ent[ENT_W-1 -: TS_W]),
      .head_addr  (head_ent[DATA_W +: ADDR_W]),
      .head_data  (head_ent[DATA_W-1:0]),
      .pop        (do_pop),
      .bus_cs_n   (bus_cs_n),
      .bus_we_n   (bus_we_n),
      .bus_addr   (bus_addr),
      .bus_data   (bus_data),
      .late_flag  (late_flag)
   );
endmodule

// File: rtl/sched_chk.sv
module sched_chk #(
   parameter int unsigned TS_W      = 32,
   parameter int unsigned ADDR_W    = 5,
   parameter int unsigned DEPTH     = 16,
   parameter int unsigned REG_COUNT = 25,
   localparam int unsigned LVL_W    = $clog2(DEPTH + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick_en,
   input logic              cmd_valid,
   input logic              cmd_ready,
   input logic [ADDR_W-1:0] cmd_addr,
   input logic              bus_cs_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              late_flag,
   input logic              addr_err_flag,
   input logic [TS_W-1:0]   cycle_q,
   input logic [LVL_W-1:0]  level
);
   logic cmd_bad, bus_legal;
   assign cmd_bad   = ({1'b0, cmd_addr} >= (ADDR_W + 1)'(REG_COUNT));
   assign bus_legal = ({1'b0, bus_addr} <  (ADDR_W + 1)'(REG_COUNT));

   p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      tick_en |=> (cycle_q == $past(cycle_q) + 1'b1));
   p_count_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_en |=> $stable(cycle_q));
   p_strobe_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_en |=> $stable(bus_cs_n));
   p_late_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      late_flag |=> late_flag);
   p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
      level <= LVL_W'(DEPTH));
   p_ready_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_ready |-> (level == LVL_W'(DEPTH)));
   p_err_raise_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_ready && cmd_bad) |=> addr_err_flag);
   p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      addr_err_flag |=> addr_err_flag);
   p_addr_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_cs_n |-> bus_legal);
   p_idle_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_en && level == '0) |=> bus_cs_n);
endmodule

bind cyc_write_sched sched_chk #(
   .TS_W(TS_W), .ADDR_W(ADDR_W), .DEPTH(DEPTH), .REG_COUNT(REG_COUNT)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .tick_en       (tick_en),
   .cmd_valid     (cmd_valid),
   .cmd_ready     (cmd_ready),
   .cmd_addr      (cmd_addr),
   .bus_cs_n      (bus_cs_n),
   .bus_addr      (bus_addr),
   .late_flag     (late_flag),
   .addr_err_flag (addr_err_flag),
   .cycle_q       (cycle_q),
   .level         (fifo_level)
);

// File: tb/tb_cyc_write_sched.sv
module tb_cyc_write_sched;
   localparam int TW   = 8;
   localparam int AW   = 5;
   localparam int DW   = 8;
   localparam int DEP  = 16;
   localparam int NREG = 25;
   localparam int MASK = (1 << TW) - 1;
   localparam int HALF = 1 << (TW - 1);

   logic          clk = 1'b0, rst_n = 1'b0, tick_en = 1'b0, cmd_valid = 1'b0;
   logic [TW-1:0] cmd_time = '0;
   logic [AW-1:0] cmd_addr = '0;
   logic [DW-1:0] cmd_data = '0;
   logic          cmd_ready, bus_cs_n, bus_we_n, late_flag, addr_err_flag;
   logic [AW-1:0] bus_addr;
   logic [DW-1:0] bus_data;

   int total = 0, bad = 0, k = 0;
   bit exp_late = 0, exp_err = 0, done = 0;
   int q_ts[$], q_ad[$], q_dt[$];

   always #4 clk = ~clk;

   cyc_write_sched #(.TS_W(TW), .ADDR_W(AW), .DATA_W(DW), .DEPTH(DEP), .REG_COUNT(NREG)) dut (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_time(cmd_time), .cmd_addr(cmd_addr), .cmd_data(cmd_data), .bus_cs_n(bus_cs_n),
      .bus_we_n(bus_we_n), .bus_addr(bus_addr), .bus_data(bus_data), .late_flag(late_flag),
      .addr_err_flag(addr_err_flag)
   );

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d (tick %0d)", req, what, act, exp, k);
      end
   endtask

   task automatic do_reset();
      @(negedge clk) rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      q_ts.delete(); q_ad.delete(); q_dt.delete();
      k = 0; exp_late = 0; exp_err = 0;
      @(negedge clk);
      chk(bus_cs_n == 1'b1, "R1", "cs_n after reset", int'(bus_cs_n), 1);
      chk(bus_we_n == 1'b1, "R1", "we_n after reset", int'(bus_we_n), 1);
      chk(cmd_ready == 1'b1, "R1", "ready after reset", int'(cmd_ready), 1);
      chk(late_flag == 1'b0, "R1", "late after reset", int'(late_flag), 0);
      chk(addr_err_flag == 1'b0, "R1", "err after reset", int'(addr_err_flag), 0);
   endtask

   // one tick: model decides the expected write from the signed age of the head
   task automatic tick(input string req);
      bit w;
      int ea, ed, d;
      w = 0; ea = 0; ed = 0;
      @(negedge clk) tick_en = 1'b1;
      if (q_ts.size() > 0) begin
         d = (k - q_ts[0]) & MASK;
         if (d < HALF) begin
            w  = 1;
            ea = q_ad[0];
            ed = q_dt[0];
            if (d != 0) exp_late = 1;
            void'(q_ts.pop_front());
            void'(q_ad.pop_front());
            void'(q_dt.pop_front());
         end
      end
      @(negedge clk) tick_en = 1'b0;
      chk(bus_cs_n == !w, req, "cs_n", int'(bus_cs_n), int'(!w));
      chk(bus_we_n == !w, req, "we_n", int'(bus_we_n), int'(!w));
      if (w) begin
         chk(int'(bus_addr) == ea, "R10", "bus_addr", int'(bus_addr), ea);
         chk(int'(bus_data) == ed, "R3", "bus_data", int'(bus_data), ed);
      end
      chk(late_flag == exp_late, "R6", "late_flag", int'(late_flag), int'(exp_late));
      @(negedge clk);
      chk(bus_cs_n == !w, "R3", "cs_n held through tick period", int'(bus_cs_n), int'(!w));
      k++;
   endtask

   task automatic push(input int a, input int dt, input int ts, output bit acc);
      @(negedge clk);
      cmd_valid = 1'b1;
      cmd_addr  = AW'(a);
      cmd_data  = DW'(dt);
      cmd_time  = TW'(ts & MASK);
      acc       = cmd_ready;
      @(negedge clk) cmd_valid = 1'b0;
      if (acc) begin
         if (a < NREG) begin
            q_ts.push_back(ts & MASK); q_ad.push_back(a); q_dt.push_back(dt);
         end else exp_err = 1;
      end
      chk(addr_err_flag == exp_err, "R8", "addr_err_flag", int'(addr_err_flag), int'(exp_err));
   endtask

   task automatic drain(input string req);
      while (q_ts.size() > 0) tick(req);
      repeat (3) tick("R9");
   endtask

   initial begin
      bit acc;
      do_reset();

      // sweep every register number, stamps one tick apart (R4, R8, R10)
      for (int a = 0; a < 32; a++) begin
         while (!cmd_ready) tick("R4");
         push(a, a * 7 + 3, a, acc);
      end
      drain("R4");
      chk(late_flag == 1'b0, "R3", "on-time sweep left late low", int'(late_flag), 0);

      // equal stamps and a gap (R4, R9)
      push(1, 8'h11, k + 3, acc);
      push(2, 8'h22, k + 3, acc);
      push(3, 8'h33, k + 6, acc);
      repeat (9) tick("R4");

      // overdue command (R6)
      do_reset();
      repeat (5) tick("R9");
      push(3, 8'h5A, k - 3, acc);
      tick("R6");
      chk(late_flag == 1'b1, "R6", "late set by overdue release", int'(late_flag), 1);

      // stamps across counter wrap (R5, R2)
      while (k < 250) tick("R9");
      push(7, 8'h77, k + 10, acc);
      push(9, 8'h99, k + 12, acc);
      repeat (16) tick("R5");

      // full queue and back-pressure (R7)
      for (int i = 0; i < DEP; i++) push(i, 16 + i, k + 40, acc);
      chk(cmd_ready == 1'b0, "R7", "ready when full", int'(cmd_ready), 0);
      push(5, 8'hAA, k + 2, acc);
      chk(acc == 1'b0, "R7", "offer while full accepted", int'(acc), 0);
      drain("R7");

      // reset mid-run clears queue and restarts counter (R1, R2)
      push(4, 8'h44, k + 20, acc);
      do_reset();
      push(6, 8'h66, 3, acc);
      repeat (30) tick("R2");

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule